// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus side of a small 8-bit processor whose low address byte and data byte share one set of pins. The core hands it one transfer at a time: an opcode fetch, a memory read or write, a port read or write, or an interrupt acknowledge. The block then walks that transfer through the clock states T1, T2, any number of wait states, and T3. It drives the high address byte, the shared low byte, an address latch pulse, a three-bit cycle status code, and active-low read and write strobes.

Each clock state lasts two clocks of `clk`. This gives the address latch pulse a falling edge in the middle of T1, while the address and status are still steady on the pins. Every output group has its own enable, so that floating pins can be observed.

On the core side, requests use a valid/ready handshake. A request transfers on a clock where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so a core that holds `req_valid` simply stalls until the running cycle has finished. Completion is reported by a one-clock `rsp_valid` pulse with no back-pressure, so the core must take `rsp_rdata` in that clock.

Top module: `busseq`

## Requirements
- R1: `req_ready` is high exactly when the block is out of reset and idle. An accepted request raises `bus_ale` on the next clock. While a cycle runs, `req_ready` stays low and the request inputs are not looked at.
- R2: T1 spans two clocks. `bus_ale` is high in the first of these clocks only. The low address stays driven on `bus_ad_o` through both clocks.
- R3: In T1, `bus_ad_o` carries `req_addr[7:0]`. For memory cycles, `bus_hi` carries `req_addr[15:8]`. For port cycles (kinds 3 and 4), `bus_hi` repeats the port number `req_addr[7:0]`.
- R4: `cyc_stat` = {io_m, s1, s0} is set from `req_kind` at the start of T1 and does not change until the cycle ends. The codes are: kind 0 opcode fetch → 011; kind 1 memory read → 010; kind 2 memory write → 001; kind 3 port read → 110; kind 4 port write → 101; kind 5 interrupt acknowledge → 111. Kinds 6 and 7 run as a memory read (010).
- R5: Write kinds (2 and 4) hold `wr_n` low, and all other kinds hold `rd_n` low. The strobe is low from the first clock of T2 through the first clock of T3. The two strobes are never low together.
- R6: For writes, `bus_ad_o` carries the write data from T2 until the end of T3, which is one clock past the rising edge of `wr_n`. For reads, `bus_ad_oe` is low from T2 to the end of the cycle.
- R7: `ready_i` is sampled only at the edge that ends T2 and at the edge that ends each wait state. Each low sample inserts one wait state of two clocks. Values of `ready_i` at any other edge have no effect. After acceptance, `rsp_valid` rises in clock 5+2W, where W is the number of wait states (clock 0 is the first clock of T1).
- R8: Read data is taken from `bus_ad_i` at the edge where `rd_n` rises. It is presented on `rsp_rdata` while `rsp_valid` is high, which is for exactly one clock, the second clock of T3. Write cycles pulse `rsp_valid` as well.
- R9: While `rst` is high, `bus_hi_oe`, `bus_ad_oe`, `cyc_stat_oe` and `strobe_oe` are low, `bus_ale` is driven low, and `req_ready` is low, even in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; two clocks form one bus clock state |
| rst | input | 1 | Asynchronous active-high reset |
| req_valid | input | 1 | Core offers a transfer |
| req_ready | output | 1 | Sequencer idle, transfer accepted this clock if valid |
| req_kind | input | 3 | Cycle kind code (see R4) |
| req_addr | input | 16 | Memory address, or port number in bits 7:0 |
| req_wdata | input | 8 | Data for write kinds |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Data captured from the bus for read kinds |
| bus_hi | output | 8 | High address byte pins |
| bus_hi_oe | output | 1 | Drive enable for `bus_hi` |
| bus_ad_o | output | 8 | Shared address/data pins, outgoing value |
| bus_ad_oe | output | 1 | Drive enable for the shared pins |
| bus_ad_i | input | 8 | Shared address/data pins, incoming value |
| bus_ale | output | 1 | Address latch pulse, never floated |
| cyc_stat | output | 3 | Status {io_m, s1, s0} |
| cyc_stat_oe | output | 1 | Drive enable for `cyc_stat` |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| strobe_oe | output | 1 | Drive enable for `rd_n` and `wr_n` |
| ready_i | input | 1 | Slave ready; low stretches the cycle |

## Verification
All eight kind codes are first run with no wait states. This separates the status codes and the strobe choice, and it shows the memory and port mappings on the high address byte. Cycles with several wait states then follow, with `ready_i` toggled at random at the clocks that are not sampled. Only a sequencer that looks at the defined sampling edges gets both the cycle length and the point where `rsp_valid` appears right. During the strobe, `bus_ad_i` carries random values at every clock except the one before the capture edge, so a capture taken one clock early or late returns the wrong byte. A reset applied in the middle of a write checks that all pins float while `bus_ale` stays low.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  localparam int KIND_W = 3;
  localparam int STAT_W = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_T1,
    S_T2,
    S_TW,
    S_T3
  } tstate_e;

  typedef struct packed {
    logic              io;
    logic              wr;
    logic [STAT_W-1:0] stat;
  } kind_info_t;

  function automatic kind_info_t decode_kind(input logic [KIND_W-1:0] k);
    kind_info_t r;
    case (k)
      3'd0:    r = '{io: 1'b0, wr: 1'b0, stat: 3'b011};
      3'd2:    r = '{io: 1'b0, wr: 1'b1, stat: 3'b001};
      3'd3:    r = '{io: 1'b1, wr: 1'b0, stat: 3'b110};
      3'd4:    r = '{io: 1'b1, wr: 1'b1, stat: 3'b101};
      3'd5:    r = '{io: 1'b0, wr: 1'b0, stat: 3'b111};
      default: r = '{io: 1'b0, wr: 1'b0, stat: 3'b010};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/busseq_ctrl.sv
module busseq_ctrl
  import busseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    ready_i,
  output tstate_e st,
  output logic    ph
);

  tstate_e st_nx;
  logic    ph_nx;

  always_comb begin
    st_nx = st;
    ph_nx = ph;
    if (st == S_IDLE) begin
      if (start) begin
        st_nx = S_T1;
        ph_nx = 1'b0;
      end
    end else if (!ph) begin
      ph_nx = 1'b1;
    end else begin
      ph_nx = 1'b0;
      case (st)
        S_T1:       st_nx = S_T2;
        S_T2, S_TW: st_nx = ready_i ? S_T3 : S_TW;
        default:    st_nx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st <= S_IDLE;
      ph <= 1'b0;
    end else begin
      st <= st_nx;
      ph <= ph_nx;
    end
  end

endmodule

// File: rtl/busseq_path.sv
module busseq_path
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [KIND_W-1:0]        kind,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W-1:0]        ad_i,
  input  tstate_e                  st,
  input  logic                     ph,
  output logic [ADDR_W-DATA_W-1:0] hi,
  output logic [DATA_W-1:0]        ad_o,
  output logic [STAT_W-1:0]        stat,
  output logic                     is_wr,
  output logic [DATA_W-1:0]        rdata
);

  localparam int HI_W = ADDR_W - DATA_W;

  kind_info_t        info_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [HI_W-1:0]   port_hi;

  // A port number is one low byte wide; fit it to the high pins.
  generate
    if (HI_W >= DATA_W) begin : g_port_wide
      assign port_hi = HI_W'(addr_q[DATA_W-1:0]);
    end else begin : g_port_narrow
      assign port_hi = addr_q[HI_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      info_q  <= decode_kind('0);
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      info_q  <= decode_kind(kind);
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  // Capture on the edge that ends the first clock of T3 (read strobe rises).
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (st == S_T3 && !ph && !info_q.wr) begin
      rdata_q <= ad_i;
    end
  end

  assign hi    = info_q.io ? port_hi : addr_q[ADDR_W-1:DATA_W];
  assign ad_o  = (st == S_T1) ? addr_q[DATA_W-1:0] : wdata_q;
  assign stat  = info_q.stat;
  assign is_wr = info_q.wr;
  assign rdata = rdata_q;

endmodule

// File: rtl/busseq.sv
module busseq
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [2:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [ADDR_W-DATA_W-1:0] bus_hi,
  output logic                     bus_hi_oe,
  output logic [DATA_W-1:0]        bus_ad_o,
  output logic                     bus_ad_oe,
  input  logic [DATA_W-1:0]        bus_ad_i,
  output logic                     bus_ale,
  output logic [2:0]               cyc_stat,
  output logic                     cyc_stat_oe,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     strobe_oe,
  input  logic                     ready_i
);

  tstate_e st;
  logic    ph;
  logic    start;
  logic    is_wr;
  logic    live;
  logic    strb;

  assign live  = !rst;
  assign start = req_valid && req_ready;

  busseq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ready_i (ready_i),
    .st      (st),
    .ph      (ph)
  );

  busseq_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_path (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .kind  (req_kind),
    .addr  (req_addr),
    .wdata (req_wdata),
    .ad_i  (bus_ad_i),
    .st    (st),
    .ph    (ph),
    .hi    (bus_hi),
    .ad_o  (bus_ad_o),
    .stat  (cyc_stat),
    .is_wr (is_wr),
    .rdata (rsp_rdata)
  );

  // Strobe window: all of T2, every wait state, first clock of T3.
  assign strb = (st == S_T2) || (st == S_TW) || (st == S_T3 && !ph);

  assign req_ready   = live && (st == S_IDLE);
  assign bus_ale     = live && (st == S_T1) && !ph;
  assign rd_n        = !(live && strb && !is_wr);
  assign wr_n        = !(live && strb && is_wr);
  assign bus_ad_oe   = live && ((st == S_T1) || (is_wr && st != S_IDLE));
  assign bus_hi_oe   = live;
  assign cyc_stat_oe = live;
  assign strobe_oe   = live;
  assign rsp_valid   = live && (st == S_T3) && ph;

endmodule

// File: rtl/busseq_chk.sv
module busseq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     rsp_valid,
  input logic                     bus_hi_oe,
  input logic [DATA_W-1:0]        bus_ad_o,
  input logic                     bus_ad_oe,
  input logic                     bus_ale,
  input logic [2:0]               cyc_stat,
  input logic                     cyc_stat_oe,
  input logic                     rd_n,
  input logic                     wr_n,
  input logic                     strobe_oe
);

  p_accept_ale_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> bus_ale);

  p_ale_hold_addr_r2: assert property (@(posedge clk) disable iff (rst)
    bus_ale |=> (!bus_ale && bus_ad_oe && $stable(bus_ad_o) && $stable(cyc_stat)));

  p_stat_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> $stable(cyc_stat));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_n || wr_n));

  p_wdata_past_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> (bus_ad_oe && $stable(bus_ad_o)));

  p_rsp_one_clock_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_rsp_after_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!rd_n || !wr_n));

  always_comb begin
    if (rst) begin
      p_float_in_reset_r9: assert (!bus_hi_oe && !bus_ad_oe && !cyc_stat_oe &&
                                   !strobe_oe && !bus_ale && !req_ready);
    end
  end

endmodule

bind busseq busseq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .bus_hi_oe   (bus_hi_oe),
  .bus_ad_o    (bus_ad_o),
  .bus_ad_oe   (bus_ad_oe),
  .bus_ale     (bus_ale),
  .cyc_stat    (cyc_stat),
  .cyc_stat_oe (cyc_stat_oe),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .strobe_oe   (strobe_oe)
);

// File: tb/busseq_test.sv
module busseq_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [7:0]  bus_hi;
  logic        bus_hi_oe;
  logic [7:0]  bus_ad_o;
  logic        bus_ad_oe;
  logic [7:0]  bus_ad_i = '0;
  logic        bus_ale;
  logic [2:0]  cyc_stat;
  logic        cyc_stat_oe;
  logic        rd_n;
  logic        wr_n;
  logic        strobe_oe;
  logic        ready_i = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  busseq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_hi(bus_hi),
    .bus_hi_oe(bus_hi_oe), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
    .bus_ad_i(bus_ad_i), .bus_ale(bus_ale), .cyc_stat(cyc_stat),
    .cyc_stat_oe(cyc_stat_oe), .rd_n(rd_n), .wr_n(wr_n),
    .strobe_oe(strobe_oe), .ready_i(ready_i)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (ok !== 1'b1) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_stat(input logic [2:0] k);
    case (k)
      3'd0:    return 3'b011;
      3'd2:    return 3'b001;
      3'd3:    return 3'b110;
      3'd4:    return 3'b101;
      3'd5:    return 3'b111;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic exp_wr(input logic [2:0] k);
    return (k == 3'd2) || (k == 3'd4);
  endfunction

  function automatic logic [7:0] exp_hi(input logic [2:0] k, input logic [15:0] a);
    return ((k == 3'd3) || (k == 3'd4)) ? a[7:0] : a[15:8];
  endfunction

  // One complete transfer with w wait states; noise toggles ready off-sample.
  task automatic txn(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                     input logic [7:0] rdv, input int w, input bit noise);
    logic [2:0] es;
    logic       wr;
    logic [7:0] eh;
    int         last;
    es   = exp_stat(k);
    wr   = exp_wr(k);
    eh   = exp_hi(k, a);
    last = 5 + 2 * w;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready when idle", 32'(req_ready), 1);
    req_valid = 1'b1;
    req_kind  = k;
    req_addr  = a;
    req_wdata = wd;
    ready_i   = noise ? 1'($urandom) : 1'b1;
    for (int n = 0; n <= last; n++) begin
      @(negedge clk);
      if (n == 0) begin
        req_valid = 1'b0;
        req_kind  = 3'($urandom);
        req_addr  = 16'($urandom);
        req_wdata = 8'($urandom);
      end
      chk(cyc_stat === es, "R4 status code", 32'(cyc_stat), 32'(es));
      chk(req_ready === 1'b0, "R1 busy", 32'(req_ready), 0);
      if (n == 0) begin
        chk(bus_ale === 1'b1, "R2 ale first clock", 32'(bus_ale), 1);
        chk(bus_ad_oe === 1'b1 && bus_ad_o === a[7:0], "R3 low address",
            32'(bus_ad_o), 32'(a[7:0]));
        chk(bus_hi === eh, "R3 high byte", 32'(bus_hi), 32'(eh));
      end else if (n == 1) begin
        chk(bus_ale === 1'b0, "R2 ale second clock", 32'(bus_ale), 0);
        chk(bus_ad_oe === 1'b1 && bus_ad_o === a[7:0], "R2 address held",
            32'(bus_ad_o), 32'(a[7:0]));
      end else if (n < last) begin
        chk(rd_n === wr && wr_n === !wr, "R5 strobe select",
            32'({rd_n, wr_n}), 32'({wr, !wr}));
        chk(rsp_valid === 1'b0, "R7 no early done", 32'(rsp_valid), 0);
        chk(bus_ad_oe === wr, "R6 bus direction", 32'(bus_ad_oe), 32'(wr));
        if (wr) chk(bus_ad_o === wd, "R6 write data", 32'(bus_ad_o), 32'(wd));
      end else begin
        chk(rd_n === 1'b1 && wr_n === 1'b1, "R5 strobes released",
            32'({rd_n, wr_n}), 32'(2'b11));
        chk(rsp_valid === 1'b1, "R7 done at 5+2W", 32'(rsp_valid), 1);
        if (wr) chk(bus_ad_oe === 1'b1 && bus_ad_o === wd, "R6 data past rise",
                    32'(bus_ad_o), 32'(wd));
        else    chk(rsp_rdata === rdv, "R8 read data", 32'(rsp_rdata), 32'(rdv));
      end
      if (n >= 3 && n <= 3 + 2 * w && ((n - 3) % 2 == 0))
        ready_i = (n == 3 + 2 * w);
      else
        ready_i = noise ? 1'($urandom) : 1'b1;
      bus_ad_i = (n == 4 + 2 * w) ? rdv : 8'($urandom);
    end
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R8 single pulse", 32'(rsp_valid), 0);
  endtask

  task automatic reset_floats(input string tag);
    chk(!bus_hi_oe && !bus_ad_oe && !cyc_stat_oe && !strobe_oe, {"R9 floats ", tag},
        32'({bus_hi_oe, bus_ad_oe, cyc_stat_oe, strobe_oe}), 0);
    chk(bus_ale === 1'b0, {"R9 ale low ", tag}, 32'(bus_ale), 0);
    chk(req_ready === 1'b0, {"R9 not ready ", tag}, 32'(req_ready), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4417));
    repeat (3) @(negedge clk);
    reset_floats("at start");
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1 && rd_n === 1'b1 && wr_n === 1'b1 && rsp_valid === 1'b0,
        "R1 idle after reset", 32'({req_ready, rd_n, wr_n, rsp_valid}), 32'(4'b1110));

    for (int k = 0; k < 8; k++)
      txn(3'(k), 16'hA55A ^ 16'(k * 16'h1111), 8'(8'h30 + k), 8'(8'hC0 + k), 0, 1'b0);
    txn(3'd2, 16'h1234, 8'h5E, 8'h00, 3, 1'b1);
    txn(3'd1, 16'hFEDC, 8'h00, 8'h9B, 2, 1'b1);
    txn(3'd3, 16'h00F1, 8'h00, 8'h27, 4, 1'b1);

    for (int i = 0; i < 60; i++)
      txn(3'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
          int'($urandom % 5), 1'b1);

    // Reset in the middle of a write, while wr_n is low.
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = 3'd2;
    req_addr  = 16'h4321;
    req_wdata = 8'hAA;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(wr_n === 1'b0, "R5 write strobe before reset", 32'(wr_n), 0);
    rst = 1'b1;
    #1;
    reset_floats("mid cycle");
    @(negedge clk);
    reset_floats("held");
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1 && wr_n === 1'b1, "R9 clean restart",
        32'({req_ready, wr_n}), 32'(2'b11));
    txn(3'd4, 16'h0077, 8'h3C, 8'h00, 1, 1'b1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule